// File: doc/BRIEF.md
# Fractional-N Dual-Modulus Divider Controller

This block sits behind the analog prescaler of a frequency synthesizer and divides the prescaled oscillator clock by a programmable effective scaling factor. The factor is a single word of the form 4N+k. The upper bits give an integer modulus N. The two lowest bits give a fraction k in quarter steps. Each output cycle lasts either N or N+1 input clocks. A small phase accumulator picks the longer cycle so that the average ratio is exactly N+k/4, and the longer cycles are spread evenly across each group of four.

Software writes a new word and pulses a commit strobe once the control transfer is complete. The word is clamped to the lowest legal factor and held in a pending register. It moves into the active divider only at a terminal count during which the charge pump reports idle, so a retune never lands while the pump is driving current. After reset the divider stays silent until the first word has been committed. When a test enable is set, a monitor output repeats the divided pulse.

Top module: `frac_div_ctrl`

## Requirements
- R1: After reset, div_pulse_o stays low until the first commit. For a committed word with k=0, the first pulse is high during the (N+1)th clock cycle after the cycle in which sf_commit_i was sampled high.
- R2: The word is decoded as 4N+k, with N = sf_word_i[SF_W-1:2] and k = sf_word_i[1:0]. With k=0, consecutive pulses are exactly N clocks apart.
- R3: In every group of four consecutive output intervals that starts at a ratio change, exactly k intervals last N+1 clocks and 4-k last N clocks.
- R4: Over 400 consecutive intervals after a ratio change, the total length is exactly 400N+100k clocks.
- R5: Interval i (counting from 0 at the ratio change) lasts N + floor((i+1)k/4) - floor(ik/4) clocks. This gives N,N,N,N+1 for k=1, alternation for k=2 and N,N+1,N+1,N+1 for k=3.
- R6: A committed word below SF_MIN is replaced by SF_MIN.
- R7: A word committed during operation leaves the interval in progress at the old ratio. The new ratio starts with the interval that begins at the next terminal count.
- R8: While cp_busy_i is high at a terminal count, the pending word is not applied and the old ratio continues. The new ratio starts at the first terminal count that sees cp_busy_i low.
- R9: test_mon_o equals div_pulse_o while test_en_i is high and stays low while test_en_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Prescaled oscillator clock being divided |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sf_word_i | input | SF_W | New effective scaling factor, 4N+k |
| sf_commit_i | input | 1 | One-cycle strobe that captures sf_word_i |
| cp_busy_i | input | 1 | Charge pump sourcing or sinking current |
| test_en_i | input | 1 | Routes the divided pulse to the monitor output |
| div_pulse_o | output | 1 | One-clock pulse at each terminal count |
| test_mon_o | output | 1 | Monitor copy of div_pulse_o, gated by test_en_i |

## Verification
The bench builds the block with SF_W=8 and SF_MIN=16. This keeps every modulus between 4 and 63 clocks, so 400-interval averages for every fraction value, plus the longest modulus, fit easily in the run. The narrow word still has the same two fraction bits and the same clamp path, so the quarter-step ordering, the clamp and the deferral under a busy charge pump are all reached at the same cycle positions as in the full-width build.

// File: rtl/frac_div_pkg.sv
`timescale 1ns/1ps
package frac_div_pkg;
  localparam int FRAC_W = 2;  // quarter-step fraction
endpackage

// File: rtl/frac_acc.sv
`timescale 1ns/1ps
module frac_acc
  import frac_div_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [FRAC_W-1:0] k_i,
  input  logic              step_i,
  input  logic              restart_i,
  output logic              carry_o
);
  logic [FRAC_W-1:0] acc_q;
  logic [FRAC_W-1:0] base;
  logic [FRAC_W:0]   sum;

  always_comb begin
    base    = restart_i ? '0 : acc_q;
    sum     = {1'b0, base} + {1'b0, k_i};
    carry_o = sum[FRAC_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (step_i) acc_q <= sum[FRAC_W-1:0];
  end

  AST_ACC_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(acc_q)); // R5
endmodule

// File: rtl/frac_cnt.sv
`timescale 1ns/1ps
module frac_cnt #(
  parameter int N_W = 13
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [N_W-1:0] n_i,
  input  logic           carry_i,
  input  logic           reload_i,
  input  logic           run_i,
  output logic           tc_o
);
  logic [N_W-1:0] cnt_q;

  assign tc_o = run_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (reload_i)                cnt_q <= n_i - N_W'(1) + N_W'(carry_i);
    else if (run_i && cnt_q != '0)    cnt_q <= cnt_q - N_W'(1);
  end

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> cnt_q <= n_i); // R2
endmodule

// File: rtl/frac_upd.sv
`timescale 1ns/1ps
module frac_upd #(
  parameter int SF_W   = 15,
  parameter int SF_MIN = 2048
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [SF_W-1:0] word_i,
  input  logic            commit_i,
  input  logic            tc_i,
  input  logic            cp_busy_i,
  output logic [SF_W-1:0] nxt_o,
  output logic            run_o,
  output logic            load_o
);
  logic [SF_W-1:0] pend_q, act_q, word_cl;
  logic            pend_vld_q, run_q;

  always_comb begin
    word_cl = (word_i < SF_W'(SF_MIN)) ? SF_W'(SF_MIN) : word_i;
    // first load is immediate; later loads wait for a quiet terminal count
    load_o  = pend_vld_q && (!run_q || (tc_i && !cp_busy_i));
    nxt_o   = load_o ? pend_q : act_q;
    run_o   = run_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q     <= '0;
      act_q      <= '0;
      pend_vld_q <= 1'b0;
      run_q      <= 1'b0;
    end else begin
      if (commit_i) pend_q <= word_cl;
      if (commit_i)    pend_vld_q <= 1'b1;
      else if (load_o) pend_vld_q <= 1'b0;
      if (load_o) begin
        act_q <= pend_q;
        run_q <= 1'b1;
      end
    end
  end

  AST_HOLD_WHEN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && cp_busy_i |=> $stable(act_q)); // R8
  AST_HOLD_MID_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && !tc_i |=> $stable(act_q)); // R7
  AST_ACT_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> act_q >= SF_W'(SF_MIN)); // R6
endmodule

// File: rtl/frac_div_ctrl.sv
`timescale 1ns/1ps
module frac_div_ctrl
  import frac_div_pkg::*;
#(
  parameter int SF_W   = 15,
  parameter int SF_MIN = 2048
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [SF_W-1:0] sf_word_i,
  input  logic            sf_commit_i,
  input  logic            cp_busy_i,
  input  logic            test_en_i,
  output logic            div_pulse_o,
  output logic            test_mon_o
);
  localparam int N_W = SF_W - FRAC_W;

  logic [SF_W-1:0] nxt;
  logic            run, load, tc, carry, step;

  assign step = load || tc;

  frac_upd #(.SF_W(SF_W), .SF_MIN(SF_MIN)) u_upd (
    .clk_i, .rst_ni,
    .word_i    (sf_word_i),
    .commit_i  (sf_commit_i),
    .tc_i      (tc),
    .cp_busy_i (cp_busy_i),
    .nxt_o     (nxt),
    .run_o     (run),
    .load_o    (load)
  );

  frac_acc u_acc (
    .clk_i, .rst_ni,
    .k_i       (nxt[FRAC_W-1:0]),
    .step_i    (step),
    .restart_i (load),
    .carry_o   (carry)
  );

  frac_cnt #(.N_W(N_W)) u_cnt (
    .clk_i, .rst_ni,
    .n_i      (nxt[SF_W-1:FRAC_W]),
    .carry_i  (carry),
    .reload_i (step),
    .run_i    (run),
    .tc_o     (tc)
  );

  assign div_pulse_o = tc;
  assign test_mon_o  = test_en_i & tc;

  AST_PULSE_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_pulse_o |=> !div_pulse_o); // R2
  AST_MON_ONLY_ON_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    test_mon_o |-> div_pulse_o && test_en_i); // R9
endmodule

// File: tb/frac_div_ctrl_tb_top.sv
`timescale 1ns/1ps
module frac_div_ctrl_tb_top;
  localparam int SF_W   = 8;
  localparam int SF_MIN = 16;
  localparam int NV     = 7;
  localparam logic [SF_W-1:0] VEC_WORD [NV] = '{8'd20, 8'd21, 8'd26, 8'd31, 8'd65, 8'd19, 8'd255};
  localparam int              VEC_N    [NV] = '{5, 5, 6, 7, 16, 4, 63};

  logic clk = 0, rst_n = 0;
  logic [SF_W-1:0] word = '0;
  logic commit = 0, busy = 0, ten = 0;
  logic pulse, mon;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  frac_div_ctrl #(.SF_W(SF_W), .SF_MIN(SF_MIN)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sf_word_i(word), .sf_commit_i(commit),
    .cp_busy_i(busy), .test_en_i(ten), .div_pulse_o(pulse), .test_mon_o(mon)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // counts negedges until a pulse is seen; clears commit after the first edge
  task automatic wait_pulse(output int cyc);
    cyc = 0;
    do begin
      @(negedge clk);
      commit = 0;
      cyc++;
    end while (!pulse && cyc < 1000);
  endtask

  function automatic int exp_iv(int n, int k, int i);
    return n + ((i + 1) * k) / 4 - (i * k) / 4;
  endfunction

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      summary();
    end
  end

  initial begin
    int iv, pulses, sum, bad;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: silent without a committed word
    pulses = 0;
    repeat (50) begin @(negedge clk); if (pulse) pulses++; end
    chk("R1 quiet before commit", pulses, 0);
    word = 8'd20; commit = 1;
    wait_pulse(iv);
    chk("R1 first pulse delay", iv, 6);
    wait_pulse(iv);
    chk("R2 k=0 interval", iv, 5);

    // table walk: commit in a pulse cycle, then check ordering and average
    for (int v = 0; v < NV; v++) begin
      int k;
      k = int'(VEC_WORD[v][1:0]);
      word = VEC_WORD[v]; commit = 1;
      wait_pulse(iv);               // interval in progress, still old ratio
      sum = 0;
      for (int i = 0; i < 400; i++) begin
        wait_pulse(iv);
        sum += iv;
        if (i < 4) chk($sformatf("R5 word %0d interval %0d", VEC_WORD[v], i), iv, exp_iv(VEC_N[v], k, i));
        if (i == 3) chk($sformatf("R3 word %0d four-group", VEC_WORD[v]), sum, 4 * VEC_N[v] + k);
      end
      chk($sformatf("R4 word %0d sum of 400", VEC_WORD[v]), sum, 400 * VEC_N[v] + 100 * k);
    end

    // R6: clamp of a small word to SF_MIN (N=4,k=0)
    word = 8'd5; commit = 1;
    wait_pulse(iv);
    for (int i = 0; i < 4; i++) begin wait_pulse(iv); chk("R6 clamped interval", iv, 4); end

    // R7: interval in progress keeps old ratio (N=4 -> N=10)
    word = 8'd40; commit = 1;
    wait_pulse(iv);
    chk("R7 old ratio completes", iv, 4);
    wait_pulse(iv);
    chk("R7 new ratio next", iv, 10);

    // R8: busy defers the change (N=10 -> N=6)
    busy = 1; word = 8'd24; commit = 1;
    for (int i = 0; i < 5; i++) begin wait_pulse(iv); chk("R8 held while busy", iv, 10); end
    busy = 0;
    wait_pulse(iv);
    chk("R8 applied after idle", iv, 6);

    // R9: monitor routing
    ten = 1; bad = 0; pulses = 0;
    repeat (30) begin @(negedge clk); if (mon != pulse) bad++; if (pulse) pulses++; end
    chk("R9 monitor follows pulse", bad, 0);
    chk("R9 pulses seen", pulses, 5);
    ten = 0; bad = 0;
    repeat (30) begin @(negedge clk); if (mon) bad++; end
    chk("R9 monitor low when disabled", bad, 0);

    // R1: reset returns to the silent state
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    pulses = 0;
    repeat (40) begin @(negedge clk); if (pulse) pulses++; end
    chk("R1 quiet after re-reset", pulses, 0);

    done = 1;
    summary();
  end
endmodule